// File: doc/BRIEF.md
# Failure Code Display Sequencer

This block chooses what a two-digit decimal failure/action readout shows and which panel indicator lamps are lit. During self-test, a failing test segment reports its address. The block latches that address and shows it as two BCD digits. When the internal computer/buffer checks have passed, the block shows an operator-action code that asks for the buffer loopback cable to be fitted. When both redundant monitor halves flag a tape-reader fault in the same cycle, the block shows a separate tape-fault code.

A rising edge on the lamp-test button starts a walk through five fixed digit pairs. While the walk runs, every panel lamp is lit except the enter and lamp-test lamps. The walk cannot start while the buffer loopback is present. Each step lasts a set number of tick enables. When the walk ends or is aborted, the readout returns to the content it had before. The seven-segment decoders and lamp drivers sit outside this block.

The lamp-test sequencer is a three-state machine. LT_IDLE waits for a start. LT_SHOW plays steps 0 to 3 and advances on dwell expiry. LT_LAST holds the final step. The named transitions are:
- IDLE→SHOW on a start: a button rising edge with the loopback low.
- SHOW→SHOW when the dwell expires before step 3.
- SHOW→LAST when the dwell expires on step 3.
- LAST→IDLE when the dwell expires.
- SHOW→IDLE and LAST→IDLE when the loopback is asserted (abort).

Top module: `fail_disp_seq`

## Requirements
- R1: A lamp-test walk shows 3 0, 2 0, 8 8, 3 2 and 7 7 in that order. The first pair appears one clock after the start edge. Each pair is held for DWELL (default 256) clocks on which `tick` is high, and clocks with `tick` low do not advance the walk.
- R2: While `buf_loop` is high, a button rising edge does not start a walk. Asserting `buf_loop` during a walk ends it on the next clock.
- R3: During a walk, `lamp_out` has every bit set except bit 0 (enter lamp) and bit 1 (lamp-test lamp), which follow `lamp_req`. Outside a walk, `lamp_out` equals `lamp_req`.
- R4: A `fail_vld` pulse captures `fail_addr` (binary). From the next clock, the address is shown as tens/ones BCD digits. Values above 99 show as 9 9.
- R5: An `action_req` pulse latches the operator-action code, which is shown as 4 5.
- R6: When `mon_flt_a` and `mon_flt_b` are high in the same clock, the tape-fault code 9 6 is latched until reset. One half alone has no effect.
- R7: Display priority, highest first: lamp-test walk, tape-fault code, failure address, action code, blank.
- R8: After the last pair, or after an abort, the display returns to the content it would show without the walk.
- R9: After reset, both digits are blank (value 15) and `lamp_out` equals `lamp_req`.
- R10: Holding the button down does not restart the walk once it ends. Only a new rising edge starts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lamp_btn | input | 1 | Lamp-test button level |
| buf_loop | input | 1 | Buffer loopback cable present |
| tick | input | 1 | Step timing enable |
| fail_vld | input | 1 | Failure address strobe |
| fail_addr | input | 8 | Failing segment address, binary |
| action_req | input | 1 | Request the operator-action code |
| mon_flt_a | input | 1 | Tape fault from monitor half A |
| mon_flt_b | input | 1 | Tape fault from monitor half B |
| lamp_req | input | NLAMP | Normal lamp requests |
| disp_tens | output | 4 | Tens digit, BCD, 15 = blank |
| disp_ones | output | 4 | Ones digit, BCD, 15 = blank |
| lamp_out | output | NLAMP | Lamp enables |

## Verification
The hardest situations to reach are the step boundaries of the walk under gated ticks, and an abort followed by a held button. Either error would leave the display one pair off or restart it silently. The stimulus first stalls `tick` for longer than a full dwell and checks that the pair does not move. It then restores `tick` and samples the last clock of the old pair and the first clock of the new one. A separate scenario raises the loopback mid-walk while the button stays held, then drops the loopback and checks that no walk restarts. The tape-fault latch is tested last, because it masks the failure address from then on.

// File: rtl/fds_pkg.sv
package fds_pkg;

    typedef enum logic [1:0] {
        LT_IDLE,
        LT_SHOW,
        LT_LAST
    } lt_state_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    localparam int          SEQ_LEN   = 5;
    localparam logic [3:0]  DIG_BLANK = 4'hF;
    localparam bcd2_t       BCD_BLANK = '{tens: 4'hF, ones: 4'hF};

    function automatic bcd2_t seq_code(input logic [2:0] step);
        bcd2_t c;
        unique case (step)
            3'd0:    c = '{tens: 4'd3, ones: 4'd0};
            3'd1:    c = '{tens: 4'd2, ones: 4'd0};
            3'd2:    c = '{tens: 4'd8, ones: 4'd8};
            3'd3:    c = '{tens: 4'd3, ones: 4'd2};
            3'd4:    c = '{tens: 4'd7, ones: 4'd7};
            default: c = BCD_BLANK;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fds_bcd.sv
module fds_bcd
    import fds_pkg::*;
#(
    parameter int BIN_W = 8,
    parameter int MAXV  = 99
) (
    input  logic [BIN_W-1:0] bin,
    output bcd2_t            bcd
);
    logic [BIN_W-1:0] sat;

    always_comb begin
        sat      = (bin > BIN_W'(MAXV)) ? BIN_W'(MAXV) : bin;
        bcd.tens = 4'(sat / BIN_W'(10));
        bcd.ones = 4'(sat % BIN_W'(10));
    end
endmodule

// File: rtl/fds_lamp_seq.sv
module fds_lamp_seq
    import fds_pkg::*;
#(
    parameter int DWELL = 256
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  btn,
    input  logic  buf_loop,
    input  logic  tick,
    output logic  active,
    output bcd2_t code
);
    localparam int CW = $clog2(DWELL + 1);

    lt_state_t     state, nxt;
    logic [2:0]    idx;
    logic [CW-1:0] cnt;
    logic          btn_q;
    logic          start;
    logic          expire;

    assign start  = btn && !btn_q && !buf_loop;
    assign expire = tick && (cnt == CW'(DWELL - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            LT_IDLE: if (start) nxt = LT_SHOW;
            LT_SHOW: begin
                if (buf_loop)                       nxt = LT_IDLE;
                else if (expire && idx == 3'd3)     nxt = LT_LAST;
            end
            LT_LAST: if (buf_loop || expire) nxt = LT_IDLE;
            default: nxt = LT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LT_IDLE;
        else        state <= nxt;
    end

    // step index, dwell counter and button edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            cnt   <= '0;
            btn_q <= 1'b0;
        end else begin
            btn_q <= btn;
            if (state == LT_IDLE || nxt == LT_IDLE) begin
                idx <= '0;
                cnt <= '0;
            end else if (tick) begin
                if (expire) begin
                    cnt <= '0;
                    idx <= idx + 3'd1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        active = (state != LT_IDLE);
        code   = active ? seq_code(idx) : BCD_BLANK;
    end

    AST_LOOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        buf_loop |=> !active);                                        // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < 3'(SEQ_LEN)));                              // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !buf_loop) |=> $stable(idx));             // R1
    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start) |=> (active && idx == 3'd0));              // R1
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && btn_q && btn) |=> !active);                       // R10
endmodule

// File: rtl/fds_prio.sv
module fds_prio
    import fds_pkg::*;
#(
    parameter logic [7:0] ACT_CODE = 8'h45,
    parameter logic [7:0] FLT_CODE = 8'h96
) (
    input  logic  lt_active,
    input  bcd2_t lt_code,
    input  logic  flt,
    input  logic  fail,
    input  bcd2_t fail_bcd,
    input  logic  act,
    output bcd2_t shown
);
    always_comb begin
        if (lt_active)  shown = lt_code;
        else if (flt)   shown = bcd2_t'(FLT_CODE);
        else if (fail)  shown = fail_bcd;
        else if (act)   shown = bcd2_t'(ACT_CODE);
        else            shown = BCD_BLANK;
    end
endmodule

// File: rtl/fail_disp_seq.sv
module fail_disp_seq
    import fds_pkg::*;
#(
    parameter int         DWELL     = 256,
    parameter int         NLAMP     = 8,
    parameter int         ENTER_IDX = 0,
    parameter int         LTEST_IDX = 1,
    parameter logic [7:0] ACT_CODE  = 8'h45,
    parameter logic [7:0] FLT_CODE  = 8'h96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lamp_btn,
    input  logic             buf_loop,
    input  logic             tick,
    input  logic             fail_vld,
    input  logic [7:0]       fail_addr,
    input  logic             action_req,
    input  logic             mon_flt_a,
    input  logic             mon_flt_b,
    input  logic [NLAMP-1:0] lamp_req,
    output logic [3:0]       disp_tens,
    output logic [3:0]       disp_ones,
    output logic [NLAMP-1:0] lamp_out
);
    localparam logic [NLAMP-1:0] KEEP_MASK =
        (NLAMP'(1) << ENTER_IDX) | (NLAMP'(1) << LTEST_IDX);

    logic       fail_q, act_q, flt_q;
    logic [7:0] addr_q;
    logic       lt_active;
    bcd2_t      lt_code, fail_bcd, shown;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            act_q  <= 1'b0;
            flt_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            if (fail_vld) begin
                fail_q <= 1'b1;
                addr_q <= fail_addr;
            end
            if (action_req)             act_q <= 1'b1;
            if (mon_flt_a && mon_flt_b) flt_q <= 1'b1;
        end
    end

    fds_lamp_seq #(.DWELL(DWELL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn      (lamp_btn),
        .buf_loop (buf_loop),
        .tick     (tick),
        .active   (lt_active),
        .code     (lt_code)
    );

    fds_bcd #(.BIN_W(8), .MAXV(99)) u_bcd (
        .bin (addr_q),
        .bcd (fail_bcd)
    );

    fds_prio #(.ACT_CODE(ACT_CODE), .FLT_CODE(FLT_CODE)) u_prio (
        .lt_active (lt_active),
        .lt_code   (lt_code),
        .flt       (flt_q),
        .fail      (fail_q),
        .fail_bcd  (fail_bcd),
        .act       (act_q),
        .shown     (shown)
    );

    always_comb begin
        disp_tens = shown.tens;
        disp_ones = shown.ones;
        lamp_out  = lt_active ? (lamp_req | ~KEEP_MASK) : lamp_req;
    end

    AST_LAMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        lt_active |-> ((&(lamp_out | KEEP_MASK)) &&
                       ((lamp_out & KEEP_MASK) == (lamp_req & KEEP_MASK)))); // R3
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> (fail_bcd.tens <= 4'd9 && fail_bcd.ones <= 4'd9));       // R4
    AST_FLT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q |=> flt_q);                                                  // R6
    AST_TEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lt_active |-> ({disp_tens, disp_ones} == lt_code));                // R7
    AST_FLT_OVER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q && !lt_active) |-> ({disp_tens, disp_ones} == FLT_CODE));   // R7
endmodule

// File: tb/test_fail_disp_seq.sv
`timescale 1ns/1ps
module test_fail_disp_seq;
    localparam int DWELL = 256;
    localparam int NL    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lamp_btn, buf_loop, tick, fail_vld, action_req;
    logic          mon_flt_a, mon_flt_b;
    logic [7:0]    fail_addr;
    logic [NL-1:0] lamp_req;
    logic [3:0]    disp_tens, disp_ones;
    logic [NL-1:0] lamp_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fail_disp_seq #(.DWELL(DWELL), .NLAMP(NL)) i_fail_disp_seq (
        .clk(clk), .rst_n(rst_n), .lamp_btn(lamp_btn), .buf_loop(buf_loop),
        .tick(tick), .fail_vld(fail_vld), .fail_addr(fail_addr),
        .action_req(action_req), .mon_flt_a(mon_flt_a), .mon_flt_b(mon_flt_b),
        .lamp_req(lamp_req), .disp_tens(disp_tens), .disp_ones(disp_ones),
        .lamp_out(lamp_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_disp(input string req, input logic [7:0] exp);
        check(req, {24'd0, disp_tens, disp_ones}, {24'd0, exp});
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // R9
    task automatic t_reset;
        check_disp("R9 blank digits", 8'hFF);
        check("R9 lamps follow req", {24'd0, lamp_out}, {24'd0, lamp_req});
    endtask

    // R5, R7
    task automatic t_codes;
        action_req = 1'b1; edges(1); action_req = 1'b0;
        check_disp("R5 action code", 8'h45);
        fail_addr = 8'd37; fail_vld = 1'b1; edges(1); fail_vld = 1'b0;
        check_disp("R7 address over action", 8'h37);
        fail_addr = 8'd150; fail_vld = 1'b1; edges(1); fail_vld = 1'b0;
        check_disp("R4 saturate to 99", 8'h99);
        fail_addr = 8'd100; fail_vld = 1'b1; edges(1); fail_vld = 1'b0;
        check_disp("R4 100 saturates", 8'h99);
        fail_addr = 8'd0; fail_vld = 1'b1; edges(1); fail_vld = 1'b0;
        check_disp("R4 address zero", 8'h00);
    endtask

    // R1, R3, R8, R10: full walk with button held throughout
    task automatic t_full_walk;
        logic [7:0] seq [5];
        seq = '{8'h30, 8'h20, 8'h88, 8'h32, 8'h77};
        lamp_btn = 1'b1; edges(1);
        for (int s = 0; s < 5; s++) begin
            check_disp("R1 first clock of step", seq[s]);
            check("R3 lamps in walk", {24'd0, lamp_out}, {24'd0, lamp_req | 8'hFC});
            edges(DWELL - 1);
            check_disp("R1 last clock of step", seq[s]);
            edges(1);
        end
        check_disp("R8 back to prior", 8'h00);
        check("R3 lamps after walk", {24'd0, lamp_out}, {24'd0, lamp_req});
        edges(20);
        check_disp("R10 held button no restart", 8'h00);
        lamp_btn = 1'b0; edges(1);
    endtask

    // R1 tick gating
    task automatic t_tick_gate;
        lamp_btn = 1'b1; edges(1); lamp_btn = 1'b0;
        tick = 1'b0; edges(600);
        check_disp("R1 no tick holds step", 8'h30);
        tick = 1'b1; edges(DWELL - 1);
        check_disp("R1 resumed last clock", 8'h30);
        edges(1);
        check_disp("R1 resumed next step", 8'h20);
        buf_loop = 1'b1; edges(1); buf_loop = 1'b0;
        check_disp("R2 abort ends walk", 8'h00);
    endtask

    // R2, R10
    task automatic t_loopback;
        buf_loop = 1'b1; lamp_btn = 1'b1; edges(3);
        check_disp("R2 no start under loopback", 8'h00);
        buf_loop = 1'b0; edges(5);
        check_disp("R10 no start without new edge", 8'h00);
        lamp_btn = 1'b0; edges(1);
        lamp_btn = 1'b1; edges(10);
        check_disp("R2 walk runs with loopback low", 8'h30);
        buf_loop = 1'b1; edges(1);
        check_disp("R8 abort restores prior", 8'h00);
        check("R3 lamps after abort", {24'd0, lamp_out}, {24'd0, lamp_req});
        buf_loop = 1'b0; edges(5);
        check_disp("R10 held after abort", 8'h00);
        lamp_btn = 1'b0; edges(1);
    endtask

    // R6, R7
    task automatic t_fault;
        mon_flt_a = 1'b1; edges(1); mon_flt_a = 1'b0;
        mon_flt_b = 1'b1; edges(1); mon_flt_b = 1'b0;
        check_disp("R6 single half ignored", 8'h00);
        mon_flt_a = 1'b1; mon_flt_b = 1'b1; edges(1);
        mon_flt_a = 1'b0; mon_flt_b = 1'b0;
        check_disp("R6 fault code", 8'h96);
        fail_addr = 8'd12; fail_vld = 1'b1; edges(1); fail_vld = 1'b0;
        check_disp("R7 fault over address", 8'h96);
        lamp_btn = 1'b1; edges(1); lamp_btn = 1'b0;
        check_disp("R7 walk over fault", 8'h30);
        edges(DWELL * 5);
        check_disp("R8 back to fault code", 8'h96);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0; lamp_btn = 1'b0; buf_loop = 1'b0; tick = 1'b1;
        fail_vld = 1'b0; fail_addr = '0; action_req = 1'b0;
        mon_flt_a = 1'b0; mon_flt_b = 1'b0; lamp_req = 8'b0000_0001;
        edges(3);
        rst_n = 1'b1; edges(1);
        t_reset();
        t_codes();
        t_full_walk();
        t_tick_gate();
        t_loopback();
        t_fault();
        report();
    end
endmodule